// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

The block is a small programmable array logic device. Eight dedicated data inputs and eight feedback signals, one per output cell, feed a shared AND plane of 32 literals: the true and the complemented form of each of the 16 signals. That plane forms 64 product terms. Each of the eight output cells ORs its own eight terms, applies a polarity choice, and drives a pin modelled as a data output plus an enable. A two-bit global mode selects among registered, simple and complex architectures. Inside that mode, a per-cell mode bit and a per-cell polarity bit choose what each cell does. Each cell can be a registered output, a combinational output, a combinational I/O whose first term gates the pin, or a pure input.

The fuse map, the per-term disable bits and the architecture word are written through a word-wide address/data port into a shadow copy. A commit strobe moves the shadow copy into the active copy and clears the cell registers. The block clock stands for the dedicated clock pin. A separate auxiliary input stands for the clock pin's data use in non-registered modes. The active-low enable pin also serves as a data input when the array is not in registered mode.

Top module: `sop_logic_array`

## Requirements
- R1: While rst_n is low, both configuration copies return to the erased state and the cell registers clear. The erased state has every fuse bit 1, no term disabled and an architecture word of 0, so after reset every io_oe bit is 0.
- R2: Writes change only the shadow copy, and the outputs do not change because of them. A cfg_commit pulse copies the shadow into the active copy at that clock edge and clears every cell register.
- R3: A product term is the AND of the literals whose fuse bit is 1. Fuse bit 2i selects signal i true and fuse bit 2i+1 selects signal i complemented. A row that selects both forms of any signal gives 0, and a row of all zeros gives 1.
- R4: Array signals 0 to 7 are ded_in[0] to ded_in[7]. Signals 8 to 15 are the feedback values of cells 0 to 7, and term t belongs to cell t/8 as slot t%8.
- R5: A disabled term reads as 0, both inside the OR and when it serves as a cell's enable term.
- R6: With the cell's polarity bit at 1 the cell's logic value is the OR of its terms; with the bit at 0 it is the inverse.
- R7: Global mode 01, cell mode bit 0: registered output. The pin shows the logic value captured at the previous clock edge, io_oe equals the inverse of oe_n, and the feedback is the pin value. A cleared register shows 1 on the pin.
- R8: Global mode 01, cell mode bit 1: combinational I/O. Term slot 0 is the enable, slots 1 to 7 form the data, and the feedback is the cell's own io_in bit.
- R9: Global mode 10: a cell with mode bit 0 is an always-enabled combinational output over all eight terms. A cell with mode bit 1 is an input with io_oe 0 and io_out 0. Middle cells 1 to 6 feed back the io_in bit of the neighbour whose index differs in bit 0.
- R10: In global modes other than 01, the feedback slot of cell 0 carries alt_in0 and the slot of cell 7 carries oe_n.
- R11: Global modes 11 and 00 make every cell a combinational I/O as in R8, whatever its mode bit. Middle cells feed back their own io_in bit.
- R12: Addresses 0 to 63 hold fuse rows for terms 0 to 63. Bit b of address 64+w is the disable bit of term 32w+b. Address 66 is the architecture word: bits [1:0] global mode, bits [9:2] cell mode bits for cells 0 to 7, bits [17:10] polarity bits for cells 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; acts as the dedicated register clock pin |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_addr | input | 7 | Configuration word address |
| cfg_wdata | input | 32 | Configuration word data |
| cfg_commit | input | 1 | Moves shadow configuration into the active copy |
| ded_in | input | 8 | Dedicated data inputs |
| alt_in0 | input | 1 | Data use of the clock pin in non-registered modes |
| oe_n | input | 1 | Shared active-low enable pin; also data in non-registered modes |
| io_in | input | 8 | Levels seen on the eight I/O pins |
| io_out | output | 8 | Data driven toward the I/O pins |
| io_oe | output | 8 | Per-pin output enable |

## Verification
The bench targets several corner cases:
- Rows that select both forms of a signal, and empty rows. Swapping their meaning would drive the wrong constant on an output.
- A disabled enable term. A design that applies disable bits only inside the OR would leave such a pin enabled.
- Feedback source by mode and cell position. A design that wires the end cells like the middle ones, or ignores the neighbour swap, shows the wrong pin value.
- Shadow writes before a commit must not leak to the outputs.
- The registered pin must read high after a commit and then toggle once per edge. A design with a missing clear or an extra pipeline stage fails here.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic [1:0] {
    MODE_REG    = 2'd0,
    MODE_SIMPLE = 2'd1,
    MODE_CPLX   = 2'd2
  } arch_mode_e;

  // Global selector: 01 registered, 10 simple, 11 and 00 complex.
  function automatic arch_mode_e decode_mode(input logic [1:0] gsel);
    case (gsel)
      2'b01:   return MODE_REG;
      2'b10:   return MODE_SIMPLE;
      default: return MODE_CPLX;
    endcase
  endfunction

endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
  parameter int NUM_TERMS = 64,
  parameter int LIT_W     = 32,
  parameter int ARCH_W    = 18,
  parameter int AW        = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [AW-1:0]                   addr,
  input  logic [LIT_W-1:0]                wdata,
  input  logic                            commit,
  output logic [NUM_TERMS-1:0][LIT_W-1:0] act_rows,
  output logic [NUM_TERMS-1:0]            act_dis,
  output logic [ARCH_W-1:0]               act_arch
);
  localparam int DIS_WORDS = NUM_TERMS / LIT_W;
  localparam int ARCH_ADDR = NUM_TERMS + DIS_WORDS;

  logic [NUM_TERMS-1:0][LIT_W-1:0] sh_rows;
  logic [NUM_TERMS-1:0]            sh_dis;
  logic [ARCH_W-1:0]               sh_arch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_rows <= '1;
      sh_dis  <= '0;
      sh_arch <= '0;
    end else if (we) begin
      for (int t = 0; t < NUM_TERMS; t++)
        if (int'(addr) == t) sh_rows[t] <= wdata;
      for (int w = 0; w < DIS_WORDS; w++)
        if (int'(addr) == NUM_TERMS + w) sh_dis[w*LIT_W +: LIT_W] <= wdata;
      if (int'(addr) == ARCH_ADDR) sh_arch <= wdata[ARCH_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_rows <= '1;
      act_dis  <= '0;
      act_arch <= '0;
    end else if (commit) begin
      act_rows <= sh_rows;
      act_dis  <= sh_dis;
      act_arch <= sh_arch;
    end
  end

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_arch));
  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> act_arch == $past(sh_arch));
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int NUM_SIG   = 16,
  parameter int NUM_TERMS = 64,
  localparam int LIT_W    = 2 * NUM_SIG
) (
  input  logic [NUM_SIG-1:0]              sig,
  input  logic [NUM_TERMS-1:0][LIT_W-1:0] rows,
  input  logic [NUM_TERMS-1:0]            dis,
  output logic [NUM_TERMS-1:0]            terms
);
  // Literal vector: even bit is the signal, odd bit its complement.
  function automatic logic [LIT_W-1:0] make_lits(input logic [NUM_SIG-1:0] s);
    logic [LIT_W-1:0] l;
    for (int i = 0; i < NUM_SIG; i++) begin
      l[2*i]   = s[i];
      l[2*i+1] = ~s[i];
    end
    return l;
  endfunction

  // A term is true when every selected literal is true.
  function automatic logic eval_term(input logic [LIT_W-1:0] row,
                                     input logic [LIT_W-1:0] lits);
    return &(~row | lits);
  endfunction

  logic [LIT_W-1:0] lits;
  assign lits = make_lits(sig);

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    assign terms[t] = eval_term(rows[t], lits) & ~dis[t];
  end
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import sop_pkg::*;
#(
  parameter int TPC    = 8,
  parameter bit IS_END = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  arch_mode_e     mode,
  input  logic           cell_m,
  input  logic           cell_p,
  input  logic [TPC-1:0] terms,
  input  logic           oe_n,
  input  logic           pin_own,
  input  logic           pin_adj,
  input  logic           end_alt,
  output logic           pad_out,
  output logic           pad_oe,
  output logic           fb
);
  logic q;
  logic is_regout, is_comb_io, is_input;
  logic sum, v;

  assign is_regout  = (mode == MODE_REG) && !cell_m;
  assign is_comb_io = ((mode == MODE_REG) && cell_m) || (mode == MODE_CPLX);
  assign is_input   = (mode == MODE_SIMPLE) && cell_m;
  assign sum        = is_comb_io ? |terms[TPC-1:1] : |terms;
  assign v          = cell_p ? sum : ~sum;

  // Register stores the inverse so a cleared register reads high on the pin.
  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= 1'b0;
    else               q <= ~v;
  end

  always_comb begin
    if (is_regout) begin
      pad_out = ~q;
      pad_oe  = ~oe_n;
    end else if (is_comb_io) begin
      pad_out = v;
      pad_oe  = terms[0];
    end else if (is_input) begin
      pad_out = 1'b0;
      pad_oe  = 1'b0;
    end else begin
      pad_out = v;
      pad_oe  = 1'b1;
    end
  end

  always_comb begin
    if (mode == MODE_REG)        fb = cell_m ? pin_own : ~q;
    else if (IS_END)             fb = end_alt;
    else if (mode == MODE_SIMPLE) fb = pin_adj;
    else                         fb = pin_own;
  end

  // R7
  reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_regout && !clr) |=> pad_out == $past(v));
  // R2
  reg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> q == 1'b0);
  // R8
  comb_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_comb_io && !terms[0]) |-> !pad_oe);
endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
  import sop_pkg::*;
#(
  parameter int NUM_DED    = 8,
  parameter int NUM_CELLS  = 8,
  parameter int TPC        = 8,
  localparam int NUM_SIG   = NUM_DED + NUM_CELLS,
  localparam int LIT_W     = 2 * NUM_SIG,
  localparam int NUM_TERMS = NUM_CELLS * TPC,
  localparam int DIS_WORDS = NUM_TERMS / LIT_W,
  localparam int ARCH_W    = 2 + 2 * NUM_CELLS,
  localparam int AW        = $clog2(NUM_TERMS + DIS_WORDS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [LIT_W-1:0]     cfg_wdata,
  input  logic                 cfg_commit,
  input  logic [NUM_DED-1:0]   ded_in,
  input  logic                 alt_in0,
  input  logic                 oe_n,
  input  logic [NUM_CELLS-1:0] io_in,
  output logic [NUM_CELLS-1:0] io_out,
  output logic [NUM_CELLS-1:0] io_oe
);
  logic [NUM_TERMS-1:0][LIT_W-1:0] act_rows;
  logic [NUM_TERMS-1:0]            act_dis;
  logic [ARCH_W-1:0]               act_arch;
  logic [NUM_TERMS-1:0]            terms;
  logic [NUM_CELLS-1:0]            fb;
  logic [NUM_SIG-1:0]              sig;
  arch_mode_e                      mode;

  sop_cfg_store #(
    .NUM_TERMS(NUM_TERMS), .LIT_W(LIT_W), .ARCH_W(ARCH_W), .AW(AW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .commit(cfg_commit),
    .act_rows(act_rows), .act_dis(act_dis), .act_arch(act_arch)
  );

  assign mode = decode_mode(act_arch[1:0]);
  assign sig  = {fb, ded_in};

  sop_and_plane #(.NUM_SIG(NUM_SIG), .NUM_TERMS(NUM_TERMS)) u_plane (
    .sig(sig), .rows(act_rows), .dis(act_dis), .terms(terms)
  );

  for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cell
    localparam int  ADJ = ((k ^ 1) < NUM_CELLS) ? (k ^ 1) : k;
    localparam bit  END = (k == 0) || (k == NUM_CELLS - 1);
    logic alt;
    assign alt = (k == 0) ? alt_in0 : oe_n;

    sop_macrocell #(.TPC(TPC), .IS_END(END)) u_mc (
      .clk(clk), .rst_n(rst_n), .clr(cfg_commit), .mode(mode),
      .cell_m(act_arch[2 + k]), .cell_p(act_arch[2 + NUM_CELLS + k]),
      .terms(terms[k*TPC +: TPC]), .oe_n(oe_n),
      .pin_own(io_in[k]), .pin_adj(io_in[ADJ]), .end_alt(alt),
      .pad_out(io_out[k]), .pad_oe(io_oe[k]), .fb(fb[k])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> io_oe == '0);
endmodule

// File: tb/sop_logic_array_bench.sv
module sop_logic_array_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_commit = 1'b0;
  logic [7:0]  ded_in = '0;
  logic        alt_in0 = 1'b0;
  logic        oe_n = 1'b0;
  logic [7:0]  io_in = '0;
  logic [7:0]  io_out, io_oe;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sop_logic_array u_sop_logic_array (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_commit(cfg_commit), .ded_in(ded_in),
    .alt_in0(alt_in0), .oe_n(oe_n), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe)
  );

  // {ded_in, io_in, alt_in0, oe_n, expected io_out} for the simple-mode map
  localparam logic [25:0] VECS [0:5] = '{
    {8'h00, 8'h00, 1'b0, 1'b0, 8'h42},
    {8'h01, 8'h04, 1'b1, 1'b0, 8'h5B},
    {8'h03, 8'hFB, 1'b0, 1'b1, 8'h62},
    {8'h1C, 8'h00, 1'b0, 1'b0, 8'h41},
    {8'hFF, 8'hFF, 1'b1, 1'b1, 8'h79},
    {8'h12, 8'h04, 1'b0, 1'b1, 8'h68}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    cfg_commit = 1'b1;
    @(negedge clk);
    cfg_commit = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset oe", io_oe, 8'h00);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 erased oe", io_oe, 8'h00);

    // Simple-mode map (R12 layout)
    wr(0,  32'h0000_0009);          // R3 d0 & ~d1
    wr(1,  32'h0000_0050);          // d2 & d3
    wr(8,  32'h0000_0100);          // R6 cell1 = d4, inverted
    wr(24, 32'h0040_0000);          // R9 cell3 reads io_in[2]
    wr(32, 32'h0001_0000);          // R10 cell0 slot = alt_in0
    wr(40, 32'h4000_0000);          // R10 cell7 slot = oe_n
    wr(48, 32'h0000_0000);          // R3 empty row -> 1
    wr(56, 32'h0000_0000);
    wr(65, 32'h0100_0000);          // R5 disable term 56
    wr(66, 32'h2 | (32'h1 << 4) | (32'hFD << 10));
    chk("R2 no effect before commit", io_oe, 8'h00);
    commit();

    foreach (VECS[i]) begin
      @(negedge clk);
      {ded_in, io_in, alt_in0, oe_n} = VECS[i][25:8];
      #1;
      chk("R3 R4 R6 R9 R10 vector out", io_out, VECS[i][7:0]);
      chk("R9 vector oe", io_oe, 8'hFB);
    end

    // R2 shadow write held until commit
    @(negedge clk);
    ded_in = 8'h10; io_in = '0; alt_in0 = 1'b0; oe_n = 1'b0;
    wr(8, 32'h0000_0400);           // cell1 would become ~d5
    #1;
    chk("R2 shadow hidden", {7'd0, io_out[1]}, 8'h00);
    commit();
    chk("R2 commit applies", {7'd0, io_out[1]}, 8'h01);

    // Registered mode
    wr(0,  32'h0002_0000);          // R7 cell0 = ~own feedback
    wr(1,  32'hFFFF_FFFF);
    wr(8,  32'h0000_0001);          // R8 enable = d0
    wr(9,  32'h0004_0000);          // data = io_in[1]
    wr(24, 32'h0000_0000);
    wr(25, 32'h0000_0000);
    wr(64, 32'h0100_0000);          // R5 disable enable term 24
    wr(66, 32'h1 | 32'h28 | (32'hFF << 10));
    ded_in = 8'h00; io_in = 8'h02; oe_n = 1'b0;
    commit();
    chk("R7 cleared pin high", {7'd0, io_out[0]}, 8'h01);
    chk("R7 oe from pin", {7'd0, io_oe[0]}, 8'h01);
    @(negedge clk); #1;
    chk("R7 toggle 1", {7'd0, io_out[0]}, 8'h00);
    @(negedge clk); #1;
    chk("R7 toggle 2", {7'd0, io_out[0]}, 8'h01);
    oe_n = 1'b1; #1;
    chk("R7 oe off", {7'd0, io_oe[0]}, 8'h00);
    chk("R8 enable low", {7'd0, io_oe[1]}, 8'h00);
    ded_in = 8'h01; #1;
    chk("R8 enable high", {7'd0, io_oe[1]}, 8'h01);
    chk("R8 own pin data", {7'd0, io_out[1]}, 8'h01);
    io_in = 8'h00; #1;
    chk("R8 own pin data low", {7'd0, io_out[1]}, 8'h00);
    chk("R5 disabled enable term", {7'd0, io_oe[3]}, 8'h00);

    // Complex mode, mode bits all set then all clear
    wr(64, 32'h0);
    wr(25, 32'h0040_0000);          // cell3 data = own io_in[3]
    wr(16, 32'h0);                  // cell2 enable = 1
    wr(17, 32'h0001_0000);          // cell2 data = cell0 slot = alt_in0
    wr(66, 32'h3 | (32'hFF << 2) | (32'hFF << 10));
    commit();
    for (int pass = 0; pass < 2; pass++) begin
      io_in = 8'h08; alt_in0 = 1'b1; #1;
      chk("R11 own pin", {7'd0, io_out[3]}, 8'h01);
      chk("R11 enable", {7'd0, io_oe[3]}, 8'h01);
      chk("R10 end slot alt", {7'd0, io_out[2]}, 8'h01);
      io_in = 8'h00; alt_in0 = 1'b0; #1;
      chk("R11 own pin low", {7'd0, io_out[3]}, 8'h00);
      chk("R10 end slot alt low", {7'd0, io_out[2]}, 8'h00);
      if (pass == 0) begin
        wr(66, 32'h3 | (32'hFF << 10));
        commit();
      end
    end

    // R1 reset returns to erased state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk); #1;
    chk("R1 reset clears oe", io_oe, 8'h00);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 after reset oe", io_oe, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule